// File: doc/BRIEF.md
# Variable-Page Address Translation Buffer

This block translates 32-bit virtual addresses to physical addresses through two fully associative arrays: a 64-entry unified array serving data accesses and a 4-entry instruction array serving fetches. Each entry carries a valid flag, an 8-bit address-space identifier, a 22-bit virtual page number, a 22-bit physical page number, a 2-bit page-size code, a 2-bit protection field and a dirty flag. Every entry applies its own page size, so 1 KB, 4 KB, 64 KB and 1 MB pages can be mixed in one array. When more than one entry matches, the block reports a distinct multiple-match result and does not report a hit.

A lookup is presented for one cycle and its result appears on registered outputs in the next cycle. On a fetch that misses the instruction array, and when refill is requested, the block searches the unified array in the same cycle. A single match there is copied into an instruction slot that a 6-bit pseudo-LRU code selects. Software-style entry loads go into the unified array at the index held by a 6-bit replace counter. The counter steps on every data lookup and wraps at a programmable boundary.

Top module: `xlat_buffer`

## Requirements
- R1: An entry whose valid flag is 0 never matches, in either array.
- R2: When `lk_use_asid` is 1, an entry matches only if its identifier equals `lk_asid`; when it is 0, the identifier is ignored.
- R3: Size code 0, 1, 2, 3 gives a page of 1 KB, 4 KB, 64 KB, 1 MB. The page base is the stored page number shifted left by 10 with the in-page bits cleared, and an address matches when it lies inside that page.
- R4: On a hit, `rs_paddr` is the physical page number shifted left by 10 with the in-page bits cleared, ORed with the in-page bits of the virtual address, and `rs_prot`/`rs_dirty` are the matched entry's fields. On a miss or multiple match, `rs_index`, `rs_paddr`, `rs_prot` and `rs_dirty` are all 0.
- R5: Two or more matching entries give `rs_multi`=1 and `rs_hit`=0. A fetch that sees this in the unified array copies nothing and leaves the LRU code unchanged.
- R6: A write with `wr_en`=1 stores the entry at the unified index equal to `rc_value`. A lookup in the following cycle sees it, and `rs_index` reports the matching position.
- R7: Each data lookup (`lk_valid`=1, `lk_fetch`=0) steps the counter: next = value+1, except 0 when value+1 equals `rc_limit` or equals 63. The counter resets to 0 and never holds 63.
- R8: A fetch that misses the instruction array with `lk_refill`=1 and matches exactly one unified entry copies that entry into the victim slot, and returns `rs_hit`=1, `rs_refill`=1, `rs_index`=victim slot. Later fetches to that page hit the instruction array with `rs_refill`=0.
- R9: A fetch that misses the instruction array with `lk_refill`=0 returns a miss and copies nothing.
- R10: With LRU code bits c5..c0, the victim is: slot 0 if c5,c4,c3=111; else slot 1 if c5=0, c2=1, c1=1; else slot 2 if c4=0, c2=0, c0=1; else slot 3 if c3..c0=0000; else slot 0.
- R11: On every instruction-array hit, including a refill into the victim slot, the code is updated: slot 0 clears c5,c4,c3; slot 1 clears c2,c1 and sets c5; slot 2 clears c0 and sets c4,c2; slot 3 sets c3,c1,c0. The code resets to 0 and is otherwise unchanged.
- R12: `rs_valid` and the result outputs update one clock after a cycle with `lk_valid`=1, and `rs_valid` is 0 after a cycle without one. After reset `rs_valid`, `rs_hit`, `rs_multi` and `rs_refill` are 0.
- R13: Fetch lookups and entry writes do not move the replace counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| lk_refill | input | 1 | Allow instruction-array refill on a fetch miss |
| lk_use_asid | input | 1 | Compare identifiers during the search |
| lk_asid | input | 8 | Current address-space identifier |
| lk_vaddr | input | 32 | Virtual address to translate |
| wr_en | input | 1 | Load an entry at the replace-counter index |
| wr_valid | input | 1 | Valid flag of the loaded entry |
| wr_asid | input | 8 | Identifier of the loaded entry |
| wr_vpn | input | 22 | Virtual page number of the loaded entry |
| wr_ppn | input | 22 | Physical page number of the loaded entry |
| wr_size | input | 2 | Size code of the loaded entry |
| wr_prot | input | 2 | Protection field of the loaded entry |
| wr_dirty | input | 1 | Dirty flag of the loaded entry |
| rc_limit | input | 6 | Wrap boundary of the replace counter |
| rs_valid | output | 1 | Result valid, one cycle after the lookup |
| rs_hit | output | 1 | Single match found |
| rs_multi | output | 1 | More than one entry matched |
| rs_refill | output | 1 | Instruction array was loaded from the unified array |
| rs_index | output | 6 | Index of the matched entry in its array |
| rs_paddr | output | 32 | Translated physical address |
| rs_prot | output | 2 | Protection field of the matched entry |
| rs_dirty | output | 1 | Dirty flag of the matched entry |
| rc_value | output | 6 | Current replace-counter value |
| lru_code | output | 6 | Current instruction-array LRU code |

## Verification
Data lookups probe pages of all four sizes at their last in-page byte and at the first byte past the page. This separates a correct per-entry mask from one fixed at a single size, and page bases whose low page-number bits must be cleared show whether the base is aligned. A 1 KB page nested inside a 64 KB page gives a multiple match, and addresses just outside the small page show that the large page still hits alone. Identifier checks repeat one address with a matching id, a differing id, and identifier comparison turned off. Fetches walk the LRU code through all four victim slots, so each selection rule and each update mask must take effect in the order the requirements give. The replace counter is driven both to a programmed boundary and to its top value.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;

  localparam int VA_W     = 32;
  localparam int PG_SHIFT = 10;
  localparam int VPN_W    = VA_W - PG_SHIFT;
  localparam int ASID_W   = 8;
  localparam int ITLB_N   = 4;
  localparam int LRU_W    = 6;

  // search key of one entry
  typedef struct packed {
    logic [ASID_W-1:0] asid;
    logic [VPN_W-1:0]  vpn;
    logic [1:0]        size;
  } key_t;

  // translation payload of one entry
  typedef struct packed {
    logic [VPN_W-1:0] ppn;
    logic [1:0]       prot;
    logic             dirty;
  } attr_t;

  // in-page offset mask for a size code
  function automatic logic [VA_W-1:0] page_mask(input logic [1:0] sz);
    logic [VA_W-1:0] m;
    m = '0;
    case (sz)
      2'd0:    m[9:0]  = '1;
      2'd1:    m[11:0] = '1;
      2'd2:    m[15:0] = '1;
      default: m[19:0] = '1;
    endcase
    return m;
  endfunction

  function automatic logic [VA_W-1:0] phys_addr(input logic [VPN_W-1:0] ppn,
                                                input logic [1:0] sz,
                                                input logic [VA_W-1:0] va);
    logic [VA_W-1:0] m;
    m = page_mask(sz);
    return ({ppn, {PG_SHIFT{1'b0}}} & ~m) | (va & m);
  endfunction

endpackage

// File: rtl/tlb_cam.sv
module tlb_cam
  import tlbx_pkg::*;
#(
  parameter int N     = 64,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]    vld,
  input  key_t [N-1:0]    keys,
  input  logic [VA_W-1:0] va,
  input  logic            use_asid,
  input  logic [ASID_W-1:0] asid,
  output logic            any,
  output logic            multi,
  output logic [IDX_W-1:0] idx
);

  logic [N-1:0] hv;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    logic id_ok;
    logic pg_ok;
    assign id_ok = !use_asid || (keys[g].asid == asid);
    assign pg_ok = ((va ^ {keys[g].vpn, {PG_SHIFT{1'b0}}}) & ~page_mask(keys[g].size)) == '0;
    assign hv[g] = vld[g] && id_ok && pg_ok;
  end

  assign any   = |hv;
  assign multi = |(hv & (hv - N'(1)));

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hv[i]) idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/replace_ctr.sv
module replace_ctr #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic [W-1:0] limit,
  output logic [W-1:0] value
);

  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic [W-1:0] inc;

  always_comb begin
    inc   = cnt_q + W'(1);
    cnt_d = ((inc == limit) || (inc == TOP)) ? '0 : inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (step) cnt_q <= cnt_d;
  end

  assign value = cnt_q;

endmodule

// File: rtl/itlb_plru.sv
module itlb_plru
  import tlbx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_en,
  input  logic [1:0]       upd_idx,
  output logic [1:0]       victim,
  output logic [LRU_W-1:0] code
);

  logic [LRU_W-1:0] code_q;
  logic [LRU_W-1:0] code_d;

  // victim selection, first rule wins
  always_comb begin
    if (code_q[5:3] == 3'b111)                            victim = 2'd0;
    else if (!code_q[5] && code_q[2] && code_q[1])        victim = 2'd1;
    else if (!code_q[4] && !code_q[2] && code_q[0])       victim = 2'd2;
    else if (code_q[3:0] == 4'b0000)                      victim = 2'd3;
    else                                                  victim = 2'd0;
  end

  // mark the used slot most recent
  always_comb begin
    case (upd_idx)
      2'd0:    code_d = code_q & 6'b000111;
      2'd1:    code_d = (code_q & 6'b111001) | 6'b100000;
      2'd2:    code_d = (code_q & 6'b111110) | 6'b010100;
      default: code_d = code_q | 6'b001011;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      code_q <= '0;
    else if (upd_en) code_q <= code_d;
  end

  assign code = code_q;

endmodule

// File: rtl/xlat_buffer.sv
module xlat_buffer
  import tlbx_pkg::*;
#(
  parameter int UTLB_N = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic              lk_fetch,
  input  logic              lk_refill,
  input  logic              lk_use_asid,
  input  logic [7:0]        lk_asid,
  input  logic [31:0]       lk_vaddr,
  input  logic              wr_en,
  input  logic              wr_valid,
  input  logic [7:0]        wr_asid,
  input  logic [21:0]       wr_vpn,
  input  logic [21:0]       wr_ppn,
  input  logic [1:0]        wr_size,
  input  logic [1:0]        wr_prot,
  input  logic              wr_dirty,
  input  logic [5:0]        rc_limit,
  output logic              rs_valid,
  output logic              rs_hit,
  output logic              rs_multi,
  output logic              rs_refill,
  output logic [5:0]        rs_index,
  output logic [31:0]       rs_paddr,
  output logic [1:0]        rs_prot,
  output logic              rs_dirty,
  output logic [5:0]        rc_value,
  output logic [5:0]        lru_code
);

  localparam int UIDX_W = $clog2(UTLB_N);
  localparam int IIDX_W = $clog2(ITLB_N);

  // ---------------- storage ----------------
  logic  [UTLB_N-1:0] u_vld;
  key_t  [UTLB_N-1:0] u_key;
  attr_t [UTLB_N-1:0] u_att;
  logic  [ITLB_N-1:0] i_vld;
  key_t  [ITLB_N-1:0] i_key;
  attr_t [ITLB_N-1:0] i_att;

  key_t  wr_key;
  attr_t wr_att;
  assign wr_key = '{asid: wr_asid, vpn: wr_vpn, size: wr_size};
  assign wr_att = '{ppn: wr_ppn, prot: wr_prot, dirty: wr_dirty};

  logic [UIDX_W-1:0] ctr;
  logic [IIDX_W-1:0] victim;
  logic              refill_go;
  logic [UIDX_W-1:0] u_idx;

  for (genvar g = 0; g < UTLB_N; g++) begin : g_uent
    logic  wen;
    logic  vld_q;
    key_t  key_q;
    attr_t att_q;
    assign wen = wr_en && (ctr == UIDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   vld_q <= 1'b0;
      else if (wen) vld_q <= wr_valid;
    end
    always_ff @(posedge clk) begin
      if (wen) begin
        key_q <= wr_key;
        att_q <= wr_att;
      end
    end
    assign u_vld[g] = vld_q;
    assign u_key[g] = key_q;
    assign u_att[g] = att_q;
  end

  for (genvar g = 0; g < ITLB_N; g++) begin : g_ient
    logic  ren;
    logic  vld_q;
    key_t  key_q;
    attr_t att_q;
    assign ren = refill_go && (victim == IIDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   vld_q <= 1'b0;
      else if (ren) vld_q <= 1'b1;
    end
    always_ff @(posedge clk) begin
      if (ren) begin
        key_q <= u_key[u_idx];
        att_q <= u_att[u_idx];
      end
    end
    assign i_vld[g] = vld_q;
    assign i_key[g] = key_q;
    assign i_att[g] = att_q;
  end

  // ---------------- search ----------------
  logic              u_any, u_multi;
  logic              i_any, i_multi;
  logic [IIDX_W-1:0] i_idx;

  tlb_cam #(.N(UTLB_N), .IDX_W(UIDX_W)) u_ucam (
    .vld(u_vld), .keys(u_key), .va(lk_vaddr), .use_asid(lk_use_asid),
    .asid(lk_asid), .any(u_any), .multi(u_multi), .idx(u_idx)
  );

  tlb_cam #(.N(ITLB_N), .IDX_W(IIDX_W)) u_icam (
    .vld(i_vld), .keys(i_key), .va(lk_vaddr), .use_asid(lk_use_asid),
    .asid(lk_asid), .any(i_any), .multi(i_multi), .idx(i_idx)
  );

  // ---------------- replacement state ----------------
  logic              lru_en;
  logic [IIDX_W-1:0] lru_idx;

  itlb_plru u_plru (
    .clk(clk), .rst_n(rst_n), .upd_en(lru_en), .upd_idx(lru_idx),
    .victim(victim), .code(lru_code)
  );

  replace_ctr #(.W(UIDX_W)) u_rctr (
    .clk(clk), .rst_n(rst_n), .step(lk_valid && !lk_fetch),
    .limit(rc_limit), .value(ctr)
  );
  assign rc_value = ctr;

  // ---------------- result selection ----------------
  logic              hit_d, multi_d, refill_d;
  logic [UIDX_W-1:0] idx_d;
  logic [VA_W-1:0]   pa_d;
  logic [1:0]        prot_d;
  logic              dirty_d;

  always_comb begin
    hit_d     = 1'b0;
    multi_d   = 1'b0;
    refill_d  = 1'b0;
    idx_d     = '0;
    pa_d      = '0;
    prot_d    = '0;
    dirty_d   = 1'b0;
    lru_en    = 1'b0;
    lru_idx   = '0;
    refill_go = 1'b0;
    if (lk_valid) begin
      if (!lk_fetch) begin
        if (u_multi) begin
          multi_d = 1'b1;
        end else if (u_any) begin
          hit_d   = 1'b1;
          idx_d   = u_idx;
          pa_d    = phys_addr(u_att[u_idx].ppn, u_key[u_idx].size, lk_vaddr);
          prot_d  = u_att[u_idx].prot;
          dirty_d = u_att[u_idx].dirty;
        end
      end else if (i_multi) begin
        multi_d = 1'b1;
      end else if (i_any) begin
        hit_d   = 1'b1;
        idx_d   = UIDX_W'(i_idx);
        pa_d    = phys_addr(i_att[i_idx].ppn, i_key[i_idx].size, lk_vaddr);
        prot_d  = i_att[i_idx].prot;
        dirty_d = i_att[i_idx].dirty;
        lru_en  = 1'b1;
        lru_idx = i_idx;
      end else if (lk_refill) begin
        if (u_multi) begin
          multi_d = 1'b1;
        end else if (u_any) begin
          hit_d     = 1'b1;
          refill_d  = 1'b1;
          refill_go = 1'b1;
          idx_d     = UIDX_W'(victim);
          pa_d      = phys_addr(u_att[u_idx].ppn, u_key[u_idx].size, lk_vaddr);
          prot_d    = u_att[u_idx].prot;
          dirty_d   = u_att[u_idx].dirty;
          lru_en    = 1'b1;
          lru_idx   = victim;
        end
      end
    end
  end

  // ---------------- output registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_valid  <= 1'b0;
      rs_hit    <= 1'b0;
      rs_multi  <= 1'b0;
      rs_refill <= 1'b0;
    end else begin
      rs_valid  <= lk_valid;
      rs_hit    <= hit_d;
      rs_multi  <= multi_d;
      rs_refill <= refill_d;
    end
  end

  always_ff @(posedge clk) begin
    if (lk_valid) begin
      rs_index <= idx_d;
      rs_paddr <= pa_d;
      rs_prot  <= prot_d;
      rs_dirty <= dirty_d;
    end
  end

endmodule

// File: rtl/xlat_buffer_chk.sv
module xlat_buffer_chk #(
  parameter int W = 6
) (
  input logic         clk,
  input logic         rst_n,
  input logic         lk_valid,
  input logic         lk_fetch,
  input logic [W-1:0] rc_limit,
  input logic         rs_valid,
  input logic         rs_hit,
  input logic         rs_multi,
  input logic         rs_refill,
  input logic [W-1:0] rc_value,
  input logic [5:0]   lru_code
);

  localparam logic [W-1:0] ONE  = W'(1);
  localparam logic [W-1:0] TOP  = {W{1'b1}};
  localparam logic [W-1:0] PEN  = TOP - ONE;

  p_result_follows_r12: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rs_valid);

  p_result_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rs_valid);

  p_hit_excl_multi_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rs_hit |-> !rs_multi);

  p_refill_is_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rs_refill |-> rs_hit);

  p_ctr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !lk_fetch && rc_value != PEN && (rc_value + ONE) != rc_limit)
      |=> rc_value == $past(rc_value) + ONE);

  p_ctr_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !lk_fetch && (rc_value == PEN || (rc_value + ONE) == rc_limit))
      |=> rc_value == '0);

  p_ctr_not_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rc_value != TOP);

  p_ctr_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_valid && !lk_fetch) |=> $stable(rc_value));

  p_lru_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> $stable(lru_code));

endmodule

bind xlat_buffer xlat_buffer_chk u_chk (.*);

// File: tb/xlat_buffer_test.sv
`timescale 1ns/1ps
module xlat_buffer_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_valid, lk_fetch, lk_refill, lk_use_asid;
  logic [7:0]  lk_asid;
  logic [31:0] lk_vaddr;
  logic        wr_en, wr_valid;
  logic [7:0]  wr_asid;
  logic [21:0] wr_vpn, wr_ppn;
  logic [1:0]  wr_size, wr_prot;
  logic        wr_dirty;
  logic [5:0]  rc_limit;
  logic        rs_valid, rs_hit, rs_multi, rs_refill;
  logic [5:0]  rs_index;
  logic [31:0] rs_paddr;
  logic [1:0]  rs_prot;
  logic        rs_dirty;
  logic [5:0]  rc_value, lru_code;

  always #2 clk = ~clk;

  xlat_buffer uut (.*);

  typedef struct packed {
    logic        hit;
    logic        multi;
    logic        refill;
    logic [5:0]  idx;
    logic [31:0] pa;
    logic [1:0]  prot;
    logic        dirty;
  } res_t;

  res_t  exp_q[$];
  string tag_q[$];
  int    checks = 0;
  int    errs   = 0;

  localparam res_t MISS  = '0;
  localparam res_t MULTI = '{hit: 1'b0, multi: 1'b1, refill: 1'b0, idx: 6'd0,
                             pa: 32'd0, prot: 2'd0, dirty: 1'b0};

  function automatic res_t hit_of(input logic [5:0] idx, input logic [31:0] pa,
                                  input logic [1:0] prot, input logic dirty,
                                  input logic refill);
    res_t r;
    r = '{hit: 1'b1, multi: 1'b0, refill: refill, idx: idx, pa: pa,
          prot: prot, dirty: dirty};
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: push expectation, present lookup for one cycle
  task automatic lookup(input bit fetch, input bit refill, input bit use_id,
                        input logic [7:0] id, input logic [31:0] va,
                        input res_t exp, input string tag);
    @(negedge clk);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    lk_valid    = 1'b1;
    lk_fetch    = fetch;
    lk_refill   = refill;
    lk_use_asid = use_id;
    lk_asid     = id;
    lk_vaddr    = va;
    @(negedge clk);
    lk_valid    = 1'b0;
  endtask

  task automatic load(input bit v, input logic [7:0] id, input logic [21:0] vpn,
                      input logic [21:0] ppn, input logic [1:0] sz,
                      input logic [1:0] pr, input bit d);
    @(negedge clk);
    wr_en = 1'b1; wr_valid = v; wr_asid = id; wr_vpn = vpn; wr_ppn = ppn;
    wr_size = sz; wr_prot = pr; wr_dirty = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // monitor: pop and compare each result
  always @(negedge clk) begin
    if (rst_n === 1'b1 && rs_valid === 1'b1) begin
      res_t act;
      act = '{hit: rs_hit, multi: rs_multi, refill: rs_refill, idx: rs_index,
              pa: rs_paddr, prot: rs_prot, dirty: rs_dirty};
      checks++;
      if (exp_q.size() == 0) begin
        errs++;
        $display("FAIL R12: unexpected result actual=%h expected=none", act);
      end else begin
        res_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (act !== e) begin
          errs++;
          $display("FAIL %s: actual=%h expected=%h", t, act, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    lk_valid = 0; lk_fetch = 0; lk_refill = 0; lk_use_asid = 0; lk_asid = 0; lk_vaddr = 0;
    wr_en = 0; wr_valid = 0; wr_asid = 0; wr_vpn = 0; wr_ppn = 0; wr_size = 0;
    wr_prot = 0; wr_dirty = 0; rc_limit = 6'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12 reset rs_valid", {31'd0, rs_valid}, 32'd0);
    check("R12 reset rs_hit",   {29'd0, rs_hit, rs_multi, rs_refill}, 32'd0);
    check("R7 reset counter",   {26'd0, rc_value}, 32'd0);
    check("R11 reset lru",      {26'd0, lru_code}, 32'd0);

    // ---- data path ----
    load(1, 8'd5, 22'h001000, 22'h048D14, 2'd1, 2'd2, 1);          // A at 0, 4K
    lookup(0, 0, 1, 8'd5, 32'h0040_0ABC, hit_of(0, 32'h1234_5ABC, 2, 1, 0), "R6 R3 R4 4K hit");
    check("R7 step", {26'd0, rc_value}, 32'd1);
    lookup(0, 0, 1, 8'd6, 32'h0040_0ABC, MISS, "R2 id mismatch");
    lookup(0, 0, 0, 8'd6, 32'h0040_0ABC, hit_of(0, 32'h1234_5ABC, 2, 1, 0), "R2 id ignored");
    lookup(0, 0, 1, 8'd5, 32'h0040_1000, MISS, "R3 past 4K page");
    load(0, 8'd0, 22'h002000, 22'h000001, 2'd0, 2'd0, 0);          // B at 4, invalid
    check("R13 write holds counter", {26'd0, rc_value}, 32'd4);
    lookup(0, 0, 0, 8'd0, 32'h0080_0010, MISS, "R1 invalid entry");
    load(1, 8'd9, 22'h00C48D, 22'h02AF37, 2'd3, 2'd3, 0);          // C at 5, 1M
    lookup(0, 0, 0, 8'd0, 32'h031F_FFF0, hit_of(5, 32'h0ABF_FFF0, 3, 0, 0), "R3 R4 1M base cleared");
    lookup(0, 0, 0, 8'd0, 32'h0320_0000, MISS, "R3 past 1M page");
    load(1, 8'd1, 22'h001400, 22'h001C00, 2'd2, 2'd1, 0);          // D at 7, 64K
    lookup(0, 0, 1, 8'd1, 32'h0050_FFFE, hit_of(7, 32'h0070_FFFE, 1, 0, 0), "R3 R4 64K hit");
    lookup(0, 0, 1, 8'd1, 32'h0051_0000, MISS, "R3 past 64K page");
    load(1, 8'd1, 22'h001421, 22'h000040, 2'd0, 2'd0, 1);          // E at 9, 1K in D
    lookup(0, 0, 1, 8'd1, 32'h0050_8410, MULTI, "R5 nested pages");
    lookup(0, 0, 1, 8'd1, 32'h0050_8800, hit_of(7, 32'h0070_8800, 1, 0, 0), "R3 past 1K page");
    lookup(0, 0, 1, 8'd1, 32'h0050_83FF, hit_of(7, 32'h0070_83FF, 1, 0, 0), "R3 before 1K page");
    check("R7 count", {26'd0, rc_value}, 32'd12);
    load(1, 8'd3, 22'h018000, 22'h0000C0, 2'd1, 2'd0, 1);          // G at 12

    // ---- fetch path ----
    lookup(1, 1, 1, 8'd1, 32'h0050_8410, MULTI, "R5 fetch multiple no refill");
    check("R5 lru unchanged", {26'd0, lru_code}, 32'h00);
    lookup(1, 0, 1, 8'd5, 32'h0040_0010, MISS, "R9 refill off");
    lookup(1, 1, 1, 8'd5, 32'h0040_0010, hit_of(3, 32'h1234_5010, 2, 1, 1), "R8 R10 victim 3");
    check("R11 after slot 3", {26'd0, lru_code}, 32'h0B);
    lookup(1, 0, 1, 8'd5, 32'h0040_0020, hit_of(3, 32'h1234_5020, 2, 1, 0), "R8 instruction hit");
    lookup(1, 1, 1, 8'd1, 32'h0050_0100, hit_of(2, 32'h0070_0100, 1, 0, 1), "R10 victim 2");
    check("R11 after slot 2", {26'd0, lru_code}, 32'h1E);
    lookup(1, 1, 0, 8'd0, 32'h031A_0000, hit_of(1, 32'h0ABA_0000, 3, 0, 1), "R10 victim 1");
    check("R11 after slot 1", {26'd0, lru_code}, 32'h38);
    lookup(1, 0, 1, 8'd1, 32'h0050_0200, hit_of(2, 32'h0070_0200, 1, 0, 0), "R11 hit slot 2");
    check("R11 after hit 2", {26'd0, lru_code}, 32'h3C);
    lookup(1, 1, 0, 8'd0, 32'h0080_0000, MISS, "R1 fetch invalid");
    lookup(1, 0, 1, 8'd6, 32'h0040_0030, MISS, "R2 instruction id mismatch");
    check("R11 miss holds lru", {26'd0, lru_code}, 32'h3C);
    lookup(1, 1, 1, 8'd3, 32'h0600_0123, hit_of(0, 32'h0003_0123, 0, 1, 1), "R10 victim 0");
    check("R11 after slot 0", {26'd0, lru_code}, 32'h04);
    check("R13 fetch holds counter", {26'd0, rc_value}, 32'd12);

    // ---- replace counter ----
    rc_limit = 6'd14;
    lookup(0, 0, 0, 8'd0, 32'hF000_0000, MISS, "R7 step to 13");
    check("R7 below limit", {26'd0, rc_value}, 32'd13);
    lookup(0, 0, 0, 8'd0, 32'hF000_0000, MISS, "R7 wrap at limit");
    check("R7 wrap at limit", {26'd0, rc_value}, 32'd0);
    load(1, 8'd0, 22'h024000, 22'h000008, 2'd1, 2'd0, 0);          // F over A at 0
    lookup(0, 0, 0, 8'd0, 32'h0900_0004, hit_of(0, 32'h0000_2004, 0, 0, 0), "R6 write at counter");
    lookup(0, 0, 0, 8'd0, 32'h0040_0ABC, MISS, "R6 old entry replaced");
    rc_limit = 6'd0;
    for (int k = 0; k < 60; k++) lookup(0, 0, 0, 8'd0, 32'hF000_0000, MISS, "R7 run");
    check("R7 reaches 62", {26'd0, rc_value}, 32'd62);
    lookup(0, 0, 0, 8'd0, 32'hF000_0000, MISS, "R7 wrap at top");
    check("R7 wrap at top", {26'd0, rc_value}, 32'd0);

    repeat (3) @(negedge clk);
    check("R12 all results seen", exp_q.size(), 32'd0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule